// File: doc/BRIEF.md
# Half-to-Single Precision Float Widener

This block widens a 16-bit IEEE 754 binary16 bit pattern into the 32-bit binary32 pattern that holds exactly the same value. Every binary16 value can be written in binary32, so the block never rounds. It covers all input classes:

- normal numbers;
- subnormal numbers, which it renormalizes into normal binary32 values instead of flushing them to zero;
- zeros of either sign;
- infinities and NaNs.

Use it wherever half-precision data enters a single-precision datapath. It takes one word per cycle. With the default parameter `OUT_REG = 1`, the result and a valid flag leave through a single register stage. With `OUT_REG = 0`, the converter is purely combinational and the valid flag follows the input strobe directly.

Top module: `half_to_single`

## Requirements
- R1: Output bit 31 (sign) always equals input bit 15, whatever the class of the input.
- R2: For an input exponent field (bits 14:10) between 1 and 30, the output exponent (bits 30:23) is the input exponent plus 112. Output bits 22:13 hold input bits 9:0, and output bits 12:0 are zero.
- R3: For an input exponent of 0 with a nonzero fraction, let p be the index of the highest set fraction bit. The output exponent is 103 + p. Output bits 22:13 are the fraction shifted left by 10 - p and kept to 10 bits, and bits 12:0 are zero.
- R4: For an input exponent of 31, the output exponent is 0xFF, bits 22:13 carry the input fraction unchanged, and bits 12:0 are zero. Infinity therefore stays infinity and NaN stays NaN.
- R5: When input bits 14:0 are all zero, output bits 30:0 are all zero, which gives a zero of the input's sign.
- R6: With `OUT_REG = 1`, `out_valid` is low after reset. `out_valid` and `single_out` reflect a word offered with `in_valid` high on the next rising clock edge.
- R7: With `OUT_REG = 1`, a cycle with `in_valid` low clears `out_valid` on the next edge and leaves `single_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks `half_in` as a word to convert |
| half_in | input | 16 | binary16 bit pattern |
| out_valid | output | 1 | Marks `single_out` as a fresh result |
| single_out | output | 32 | binary32 bit pattern |

## Verification
With the default registered stage, each result and its valid flag are due exactly one rising edge after the word is offered. The bench drives each input on a falling edge and samples on the following falling edge, which is half a period after the register updates.

All 65536 patterns are streamed back to back, so each cycle's sample belongs to the word driven one cycle earlier. The hold check drops the strobe for one cycle and compares the output against the last word converted.

// File: rtl/half_to_single.sv
module half_to_single #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] half_in,
  output logic        out_valid,
  output logic [31:0] single_out
);
  localparam int HEXP = 5;
  localparam int HFRC = 10;
  localparam int SEXP = 8;
  localparam int SFRC = 23;
  localparam int PAD  = SFRC - HFRC;
  localparam int BIAS_GAP = 127 - 15;
  localparam int SUB_BASE = BIAS_GAP - HFRC + 1;

  logic            sgn;
  logic [HEXP-1:0] hexp;
  logic [HFRC-1:0] hfrc;
  assign {sgn, hexp, hfrc} = half_in;

  logic            is_top, is_low;
  assign is_top = &hexp;
  assign is_low = (hexp == '0);

  logic [3:0]      lead_pos;
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < HFRC; i++)
      if (hfrc[i]) lead_pos = 4'(i);
  end

  logic [3:0]      norm_sh;
  logic [HFRC-1:0] sub_frc;
  assign norm_sh = 4'(HFRC) - lead_pos;
  assign sub_frc = HFRC'(hfrc << norm_sh);

  logic [SEXP-1:0] oexp;
  logic [HFRC-1:0] ofrc;
  always_comb begin
    if (is_top) begin
      oexp = '1;
      ofrc = hfrc;
    end else if (is_low && hfrc == '0) begin
      oexp = '0;
      ofrc = '0;
    end else if (is_low) begin
      oexp = SEXP'(SUB_BASE) + SEXP'(lead_pos);
      ofrc = sub_frc;
    end else begin
      oexp = SEXP'(hexp) + SEXP'(BIAS_GAP);
      ofrc = hfrc;
    end
  end

  logic [31:0] wide;
  assign wide = {sgn, oexp, ofrc, {PAD{1'b0}}};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid  <= 1'b0;
          single_out <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) single_out <= wide;
        end
      end
    end else begin : g_comb
      assign out_valid  = in_valid;
      assign single_out = wide;
    end
  endgenerate
endmodule

// File: rtl/half_to_single_chk.sv
module half_to_single_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] half_in,
  input logic        out_valid,
  input logic [31:0] single_out
);
  generate
    if (OUT_REG) begin : g_seq
      // R6
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R7
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(single_out));
      // R1
      sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> single_out[31] == $past(half_in[15]));
      // R2
      normal_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:10] != 5'd0 && half_in[14:10] != 5'd31)
        |=> single_out[30:23] == 8'($past(half_in[14:10])) + 8'd112);
      // R4
      special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:10] == 5'd31)
        |=> single_out[30:23] == 8'hFF && single_out[22:13] == $past(half_in[9:0])
            && single_out[12:0] == 13'd0);
      // R5
      zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:0] == 15'd0) |=> single_out[30:0] == 31'd0);
    end else begin : g_cmb
      // R1
      sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> single_out[31] == half_in[15]);
      // R4
      special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:10] == 5'd31)
        |-> single_out[30:23] == 8'hFF && single_out[22:13] == half_in[9:0]);
      // R5
      zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:0] == 15'd0) |-> single_out[30:0] == 31'd0);
      // R2
      normal_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_in[14:10] != 5'd0 && half_in[14:10] != 5'd31)
        |-> single_out[30:23] == 8'(half_in[14:10]) + 8'd112);
    end
  endgenerate
endmodule

bind half_to_single half_to_single_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_in(half_in),
  .out_valid(out_valid), .single_out(single_out)
);

// File: tb/tb_half_to_single.sv
module tb_half_to_single;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] half_in = '0;
  logic        out_valid;
  logic [31:0] single_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  half_to_single dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_in(half_in),
    .out_valid(out_valid), .single_out(single_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [15:0] h);
    logic        s;
    int          e, ex;
    logic [10:0] m;
    s = h[15];
    e = int'(h[14:10]);
    m = {1'b0, h[9:0]};
    if (e == 31) return {s, 8'hFF, h[9:0], 13'd0};
    if (e == 0 && m == 0) return {s, 31'd0};
    if (e == 0) begin
      ex = 113;
      while (m[10] == 1'b0) begin
        m = m << 1;
        ex = ex - 1;
      end
      return {s, 8'(ex), m[9:0], 13'd0};
    end
    return {s, 8'(e + 112), h[9:0], 13'd0};
  endfunction

  function automatic string req_of(input logic [15:0] h);
    if (h[14:10] == 5'd31) return "R4";
    if (h[14:0] == 15'd0)  return "R5";
    if (h[14:10] == 5'd0)  return "R3";
    return "R2";
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic convert_one(input logic [15:0] h, input string req, input logic [31:0] exp);
    half_in = h;
    in_valid = 1'b1;
    @(negedge clk);
    check32(req, single_out, exp);
    check32("R6", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    check32("R6", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R6", {31'd0, out_valid}, 32'd0);

    convert_one(16'h3C00, "R2", 32'h3F800000);
    convert_one(16'h0001, "R3", 32'h33800000);
    convert_one(16'h03FF, "R3", 32'h387FC000);
    convert_one(16'h7C00, "R4", 32'h7F800000);
    convert_one(16'hFC00, "R4", 32'hFF800000);
    convert_one(16'h8000, "R5", 32'h80000000);
    convert_one(16'h7E00, "R4", 32'h7FC00000);
    convert_one(16'h0000, "R5", 32'h00000000);
    convert_one(16'hC000, "R1", 32'hC0000000);

    // R7 hold: strobe low keeps last result, clears valid
    in_valid = 1'b0;
    half_in = 16'h3C00;
    @(negedge clk);
    check32("R7", single_out, 32'hC0000000);
    check32("R7", {31'd0, out_valid}, 32'd0);

    // exhaustive sweep, one word per cycle
    for (int v = 0; v < 65536; v++) begin
      half_in = 16'(v);
      in_valid = 1'b1;
      @(negedge clk);
      check32(req_of(16'(v)), single_out, model(16'(v)));
      // R1
      check32("R1", {31'd0, single_out[31]}, {31'd0, v[15]});
    end
    in_valid = 1'b0;
    @(negedge clk);
    check32("R7", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule